// File: doc/BRIEF.md
# Fall-Through FIFO Controller

A first-in first-out buffer wrapped around a two-port memory. The controller keeps its own write and read addresses, so a producer only raises a write enable with data and a consumer only raises a read enable. Write and read words share one width. One parameter selects whether both sides run from one clock or from two unrelated clocks. A second parameter selects how read data is presented: in standard mode a word appears one read-clock cycle after its read is accepted; in fall-through mode the oldest stored word is already on the output whenever `empty` is low, and a read enable pops it.

In the two-clock build, each pointer is converted to Gray code, registered, and passed through two synchronising flops before the other domain uses it. The write domain derives `full` and the read domain derives `empty`. Because both flags work from a pointer that may lag, each can only err on the safe side. Both almost thresholds are run-time inputs. All flags and error pulses come from registers.

Top module: `fwft_fifo`

## Requirements
- R1: Every accepted word is delivered exactly once, in the order written, in both clocking modes and both output modes.
- R2: With capacity 2^ADDR_W (16 by default), `full` is high once 16 words are held and stable. A write while `full` is high stores nothing, and `overflow` is high for exactly the one write-clock cycle after it.
- R3: `empty` is high when no word can be read. A read while `empty` is high removes nothing, and `underflow` is high for exactly the one read-clock cycle after it.
- R4: Once stable, `almost_full` is high exactly when occupancy + `af_thresh` >= 16, with `af_thresh` an unsigned ADDR_W+1 bit count.
- R5: Once stable, `almost_empty` is high exactly when occupancy <= `ae_thresh`, with `ae_thresh` an unsigned ADDR_W+1 bit count. Occupancy counts every written word that has not been popped by a read.
- R6: In standard mode (FALL_THROUGH=0), `rd_data` carries the popped word in the read-clock cycle after the cycle in which `rd_enable` was high with `empty` low.
- R7: In fall-through mode (FALL_THROUGH=1), while `empty` is low, `rd_data` already shows the oldest word with no read requested. It holds that word until a read pops it in the cycle `rd_enable` is high.
- R8: In two-clock mode (DUAL_CLK=1), each pointer crossing changes at most one bit per clock. After traffic stops, every flag settles to its exact value within six cycles of each clock.
- R9: During and right after a synchronous active-high reset: `empty` = 1, `almost_empty` = 1, `full` = 0, `overflow` = 0, `underflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock (also the read clock in single-clock mode) |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_enable | input | 1 | Request to store `wr_data` |
| wr_data | input | DATA_W | Word to store |
| af_thresh | input | ADDR_W+1 | Almost-full offset below capacity |
| full | output | 1 | No free location |
| almost_full | output | 1 | Occupancy within `af_thresh` of capacity |
| overflow | output | 1 | One-cycle pulse after a refused write |
| rd_clk | input | 1 | Read-side clock (tie to `wr_clk` in single-clock mode) |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_enable | input | 1 | Request to pop a word |
| ae_thresh | input | ADDR_W+1 | Almost-empty offset above zero |
| rd_data | output | DATA_W | Read word |
| empty | output | 1 | No word available |
| almost_empty | output | 1 | Occupancy at or below `ae_thresh` |
| underflow | output | 1 | One-cycle pulse after a refused read |

## Verification
The hardest state to reach is a full FIFO in two-clock mode that is being refilled just as space is freed. Here the write side acts on a lagging copy of the read pointer, and the fall-through stage prefetches in the same cycle as a pop. The stimulus drives the producer and the consumer at the same time, first with the read clock slower than the write clock and then faster. It fills to capacity with the consumer halted before forcing a refused write. It also parks occupancy exactly on each threshold boundary, so that the flags are checked against a queue model once both domains have settled.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // Gray code helpers on a fixed wide word; callers truncate to their width.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port with enable: maps onto a block RAM output latch.
  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side #(
  parameter int AW    = 4,
  parameter bit ASYNC = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW:0]   af_thr,
  input  logic [AW:0]   fgray_in,
  output logic          accept,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull,
  output logic          overflow
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] wptr, wptr_nxt, fptr_w, lvl_nxt;

  generate
    if (ASYNC) begin : g_cross
      logic [CW-1:0] s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= '0;
          s2 <= '0;
        end else begin
          s1 <= fgray_in;
          s2 <= s1;
        end
      end
      assign fptr_w = CW'(fifo_pkg::gray_to_bin(32'(s2)));
    end else begin : g_direct
      assign fptr_w = CW'(fifo_pkg::gray_to_bin(32'(fgray_in)));
    end
  endgenerate

  assign accept   = wr_en & ~full;
  assign wptr_nxt = wptr + CW'(accept);
  assign lvl_nxt  = wptr_nxt - fptr_w;
  assign waddr    = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      wgray    <= '0;
      full     <= 1'b0;
      afull    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wptr     <= wptr_nxt;
      wgray    <= CW'(fifo_pkg::bin_to_gray(32'(wptr_nxt)));
      full     <= (lvl_nxt == CW'(DEPTH));
      afull    <= (({1'b0, lvl_nxt} + {1'b0, af_thr}) >= (CW+1)'(DEPTH));
      overflow <= wr_en & full;
    end
  end

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (wptr - fptr_w) <= CW'(DEPTH));
  assert_ovf_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> overflow);
  assert_ovf_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && full) |=> !overflow);
  assert_gray_step_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side #(
  parameter int AW    = 4,
  parameter bit ASYNC = 1'b1,
  parameter bit FWFT  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   ae_thr,
  input  logic [AW:0]   wgray_in,
  output logic          fetch,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   fgray,
  output logic          empty,
  output logic          aempty,
  output logic          underflow
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] wsync, fptr, fptr_nxt, mptr, level, level_nxt;
  logic          accept;

  generate
    if (ASYNC) begin : g_cross
      logic [CW-1:0] s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= '0;
          s2 <= '0;
        end else begin
          s1 <= wgray_in;
          s2 <= s1;
        end
      end
      assign wsync = CW'(fifo_pkg::gray_to_bin(32'(s2)));
    end else begin : g_direct
      assign wsync = CW'(fifo_pkg::gray_to_bin(32'(wgray_in)));
    end
  endgenerate

  // The freed pointer advances only when the consumer pops a word.
  assign accept    = rd_en & ~empty;
  assign fptr_nxt  = fptr + CW'(accept);
  assign level     = wsync - fptr;
  assign level_nxt = wsync - fptr_nxt;
  assign raddr     = mptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fptr      <= '0;
      fgray     <= '0;
      aempty    <= 1'b1;
      underflow <= 1'b0;
    end else begin
      fptr      <= fptr_nxt;
      fgray     <= CW'(fifo_pkg::bin_to_gray(32'(fptr_nxt)));
      aempty    <= (level_nxt <= ae_thr);
      underflow <= rd_en & empty;
    end
  end

  generate
    if (FWFT) begin : g_fwft
      // The memory output register is the staging register. It is refilled
      // in the same edge as a pop, so there is no bubble between words.
      logic ovalid;
      assign fetch = (wsync != mptr) & (~ovalid | rd_en);
      always_ff @(posedge clk) begin
        if (rst) begin
          mptr   <= '0;
          ovalid <= 1'b0;
        end else begin
          mptr   <= mptr + CW'(fetch);
          ovalid <= fetch | (ovalid & ~rd_en);
        end
      end
      assign empty = ~ovalid;

      assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!empty && !rd_en) |=> !empty);
    end else begin : g_std
      assign fetch = accept;
      assign mptr  = fptr;
      always_ff @(posedge clk) begin
        if (rst) empty <= 1'b1;
        else     empty <= (level_nxt == '0);
      end
    end
  endgenerate

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  assert_empty_level_R3: assert property (@(posedge clk) disable iff (rst)
    !empty |-> (level != '0));
  assert_unf_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> underflow);
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo #(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 4,
  parameter bit DUAL_CLK     = 1'b1,
  parameter bit FALL_THROUGH = 1'b1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   af_thresh,
  output logic              full,
  output logic              almost_full,
  output logic              overflow,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_enable,
  input  logic [ADDR_W:0]   ae_thresh,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              underflow
);
  localparam int CNT_W = ADDR_W + 1;

  logic              wr_accept, rd_fetch;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  wgray, fgray;

  fifo_wr_side #(.AW(ADDR_W), .ASYNC(DUAL_CLK)) u_wr (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .wr_en    (wr_enable),
    .af_thr   (af_thresh),
    .fgray_in (fgray),
    .accept   (wr_accept),
    .waddr    (waddr),
    .wgray    (wgray),
    .full     (full),
    .afull    (almost_full),
    .overflow (overflow)
  );

  fifo_rd_side #(.AW(ADDR_W), .ASYNC(DUAL_CLK), .FWFT(FALL_THROUGH)) u_rd (
    .clk       (rd_clk),
    .rst       (rd_rst),
    .rd_en     (rd_enable),
    .ae_thr    (ae_thresh),
    .wgray_in  (wgray),
    .fetch     (rd_fetch),
    .raddr     (raddr),
    .fgray     (fgray),
    .empty     (empty),
    .aempty    (almost_empty),
    .underflow (underflow)
  );

  fifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk  (wr_clk),
    .we    (wr_accept),
    .waddr (waddr),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .re    (rd_fetch),
    .raddr (raddr),
    .rdata (rd_data)
  );
endmodule

// File: tb/fwft_fifo_test.sv
module fwft_fifo_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rclk = 1'b0, rst = 1'b1;
  int   rhalf = 13;
  initial forever #10 clk = ~clk;
  initial forever #(rhalf) rclk = ~rclk;

  // dual-clock, fall-through instance
  logic       a_wr_en, a_rd_en, a_full, a_afull, a_ovf, a_empty, a_aempty, a_unf;
  logic [7:0] a_wr_data, a_rd_data;
  logic [4:0] a_af, a_ae;
  // single-clock, standard instance
  logic       s_wr_en, s_rd_en, s_full, s_afull, s_ovf, s_empty, s_aempty, s_unf;
  logic [7:0] s_wr_data, s_rd_data;
  logic [4:0] s_af, s_ae;

  fwft_fifo uut (
    .wr_clk(clk), .wr_rst(rst), .wr_enable(a_wr_en), .wr_data(a_wr_data),
    .af_thresh(a_af), .full(a_full), .almost_full(a_afull), .overflow(a_ovf),
    .rd_clk(rclk), .rd_rst(rst), .rd_enable(a_rd_en), .ae_thresh(a_ae),
    .rd_data(a_rd_data), .empty(a_empty), .almost_empty(a_aempty), .underflow(a_unf)
  );

  fwft_fifo #(.DUAL_CLK(1'b0), .FALL_THROUGH(1'b0)) uut_std (
    .wr_clk(clk), .wr_rst(rst), .wr_enable(s_wr_en), .wr_data(s_wr_data),
    .af_thresh(s_af), .full(s_full), .almost_full(s_afull), .overflow(s_ovf),
    .rd_clk(clk), .rd_rst(rst), .rd_enable(s_rd_en), .ae_thresh(s_ae),
    .rd_data(s_rd_data), .empty(s_empty), .almost_empty(s_aempty), .underflow(s_unf)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] q_a[$], q_s[$];
  logic [7:0] a_next = 8'h40, s_next = 8'h01, exp_a, exp_s;
  bit s_acc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic flags_ok(input string ctx, input int occ, input int af, input int ae,
                          input logic f, input logic afo, input logic e, input logic aeo);
    check(f == (occ >= DEPTH), $sformatf("R2 %s full", ctx), int'(f), int'(occ >= DEPTH));
    check(afo == (occ + af >= DEPTH), $sformatf("R4 %s almost_full", ctx), int'(afo), int'(occ + af >= DEPTH));
    check(e == (occ == 0), $sformatf("R3 %s empty", ctx), int'(e), int'(occ == 0));
    check(aeo == (occ <= ae), $sformatf("R5 %s almost_empty", ctx), int'(aeo), int'(occ <= ae));
  endtask

  // Monitor, standard instance: data lands one cycle after an accepted read.
  always @(negedge clk) begin
    #1;
    if (s_acc) begin
      if (q_s.size() == 0) check(1'b0, "R1 std read beyond model", 0, 1);
      else begin
        exp_s = q_s.pop_front();
        check(s_rd_data == exp_s, "R1 R6 std data", int'(s_rd_data), int'(exp_s));
      end
    end
    s_acc = !rst && s_rd_en && !s_empty;
  end

  // Monitor, fall-through instance: the popped word is on the output now.
  always @(negedge rclk) begin
    #1;
    if (!rst && a_rd_en && !a_empty) begin
      if (q_a.size() == 0) check(1'b0, "R1 fwft read beyond model", 0, 1);
      else begin
        exp_a = q_a.pop_front();
        check(a_rd_data == exp_a, "R1 R7 fwft data", int'(a_rd_data), int'(exp_a));
      end
    end
  end

  task automatic settle();
    repeat (6) @(negedge clk);
    repeat (6) @(negedge rclk);
    #2;
  endtask

  task automatic s_write(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_wr_en = !s_full;
      s_wr_data = s_next;
      if (!s_full) begin q_s.push_back(s_next); s_next++; end
    end
    @(negedge clk); s_wr_en = 1'b0;
  endtask

  task automatic s_read(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_rd_en = 1'b1;
    end
    @(negedge clk); s_rd_en = 1'b0;
  endtask

  task automatic s_mix(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_wr_en = !s_full && (i % 3 != 1);
      s_wr_data = s_next;
      if (s_wr_en) begin q_s.push_back(s_next); s_next++; end
      s_rd_en = (i % 4 != 3) && (i > 5);
    end
    @(negedge clk); s_wr_en = 1'b0; s_rd_en = 1'b0;
  endtask

  task automatic s_drain();
    for (int i = 0; i < 100 && q_s.size() != 0; i++) begin
      @(negedge clk); s_rd_en = 1'b1;
    end
    @(negedge clk); s_rd_en = 1'b0;
  endtask

  task automatic a_write(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a_wr_en = !a_full && (gap == 0 || i % gap != 0);
      a_wr_data = a_next;
      if (a_wr_en) begin q_a.push_back(a_next); a_next++; end
    end
    @(negedge clk); a_wr_en = 1'b0;
  endtask

  task automatic a_read(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); a_rd_en = (gap == 0 || i % gap != 0);
    end
    @(negedge rclk); a_rd_en = 1'b0;
  endtask

  task automatic a_fill();
    for (int i = 0; i < 300 && q_a.size() < DEPTH; i++) begin
      @(negedge clk);
      a_wr_en = !a_full;
      a_wr_data = a_next;
      if (a_wr_en) begin q_a.push_back(a_next); a_next++; end
    end
    @(negedge clk); a_wr_en = 1'b0;
  endtask

  task automatic a_drain();
    for (int i = 0; i < 300 && q_a.size() != 0; i++) begin
      @(negedge rclk); a_rd_en = 1'b1;
    end
    @(negedge rclk); a_rd_en = 1'b0;
  endtask

  initial begin
    a_wr_en = 0; a_rd_en = 0; a_wr_data = 0; a_af = 5'd4; a_ae = 5'd3;
    s_wr_en = 0; s_rd_en = 0; s_wr_data = 0; s_af = 5'd3; s_ae = 5'd2;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R9 reset state
    check(s_empty == 1 && s_aempty == 1, "R9 std empty flags", int'({s_empty, s_aempty}), 3);
    check(s_full == 0 && s_ovf == 0 && s_unf == 0, "R9 std full/pulses", int'({s_full, s_ovf, s_unf}), 0);
    check(a_empty == 1 && a_aempty == 1, "R9 fwft empty flags", int'({a_empty, a_aempty}), 3);
    check(a_full == 0 && a_ovf == 0 && a_unf == 0, "R9 fwft full/pulses", int'({a_full, a_ovf, a_unf}), 0);

    // Standard single-clock: threshold boundaries, full, overflow, underflow
    s_write(12); settle(); flags_ok("std occ12", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    s_write(1);  settle(); flags_ok("std occ13", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    s_write(5);  settle(); flags_ok("std occ16", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    @(negedge clk); s_wr_en = 1'b1; s_wr_data = 8'hEE;
    @(negedge clk); s_wr_en = 1'b0; #1;
    check(s_ovf == 1, "R2 std overflow pulse", int'(s_ovf), 1);
    @(negedge clk); #1;
    check(s_ovf == 0, "R2 std overflow one cycle", int'(s_ovf), 0);
    settle(); flags_ok("std after refused write", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    s_read(13); settle(); flags_ok("std occ3", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    s_read(1);  settle(); flags_ok("std occ2", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    s_drain();  settle(); flags_ok("std drained", q_s.size(), 3, 2, s_full, s_afull, s_empty, s_aempty);
    @(negedge clk); s_rd_en = 1'b1;
    @(negedge clk); s_rd_en = 1'b0; #1;
    check(s_unf == 1, "R3 std underflow pulse", int'(s_unf), 1);
    @(negedge clk); #1;
    check(s_unf == 0, "R3 std underflow one cycle", int'(s_unf), 0);
    s_af = 5'd0; s_ae = 5'd0;
    s_mix(80); settle(); flags_ok("std mixed", q_s.size(), 0, 0, s_full, s_afull, s_empty, s_aempty);
    s_drain(); settle(); flags_ok("std mixed drained", q_s.size(), 0, 0, s_full, s_afull, s_empty, s_aempty);

    // Dual-clock fall-through, read clock slower
    a_write(3, 0); settle();
    check(a_empty == 0, "R7 word shown before read", int'(a_empty), 0);
    check(a_rd_data == q_a[0], "R7 oldest word on output", int'(a_rd_data), int'(q_a[0]));
    repeat (5) @(negedge rclk); #1;
    check(a_rd_data == q_a[0], "R7 output held without read", int'(a_rd_data), int'(q_a[0]));
    flags_ok("R8 fwft occ3", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    a_fill(); settle(); flags_ok("R8 fwft full", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    @(negedge clk); a_wr_en = 1'b1; a_wr_data = 8'hEE;
    @(negedge clk); a_wr_en = 1'b0; #1;
    check(a_ovf == 1, "R2 fwft overflow pulse", int'(a_ovf), 1);
    @(negedge clk); #1;
    check(a_ovf == 0, "R2 fwft overflow one cycle", int'(a_ovf), 0);
    a_drain(); settle(); flags_ok("R8 fwft drained", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    @(negedge rclk); a_rd_en = 1'b1;
    @(negedge rclk); a_rd_en = 1'b0; #1;
    check(a_unf == 1, "R3 fwft underflow pulse", int'(a_unf), 1);
    @(negedge rclk); #1;
    check(a_unf == 0, "R3 fwft underflow one cycle", int'(a_unf), 0);
    fork
      a_write(60, 3);
      a_read(90, 4);
    join
    settle(); flags_ok("R8 fwft slow reader", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    a_drain();

    // Read clock faster than write clock
    rhalf = 4;
    fork
      a_write(60, 0);
      a_read(150, 3);
    join
    settle(); flags_ok("R8 fwft fast reader", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    a_drain();
    a_write(7, 0); settle(); flags_ok("R8 fwft occ7", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    a_read(4, 0);  settle(); flags_ok("R8 fwft after four pops", q_a.size(), 4, 3, a_full, a_afull, a_empty, a_aempty);
    a_drain(); settle();

    check(q_s.size() == 0, "R1 std all words delivered", q_s.size(), 0);
    check(q_a.size() == 0, "R1 fwft all words delivered", q_a.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule